// File: doc/BRIEF.md
# Multi-Channel Task Watchdog Aggregator

This block sits between a periodic millisecond tick and a hardware watchdog. It holds eight independent task timers. Each timer has its own limit and its own enable bit. While every enabled timer stays within its limit, the block answers each tick with a one-cycle service pulse for the hardware watchdog. Software tasks keep their own timer alive by writing a clear command for their channel.

When any enabled timer runs past its limit, the block stops issuing service pulses for good. The hardware watchdog then starves and resets the system. A sticky status vector records which channels had run out in the first cycle the overrun was seen, so the culprit can be identified after the fact. Disabled channels hold their timer at zero and never block service. Timers saturate at their maximum value instead of wrapping.

Top module: `task_wdog_agg`

## Requirements
- R1: After reset, `kick_o` is low, `stall_o` is all zero and `tripped_o` is low. Every channel is disabled and its limit is the all-ones value.
- R2: While no trip has happened and no enabled channel is over its limit, every cycle with `tick_i` high makes `kick_o` high for exactly the next cycle. A cycle without a tick gives no pulse.
- R3: Each enabled channel's timer rises by one on every tick. A channel is over its limit when its timer is strictly greater than its limit. So with limit T and no clears, ticks 1 to T+1 after a clear are serviced, and the next tick is not.
- R4: Once a trip has latched, `kick_o` stays low until reset, whatever is written or ticked afterwards.
- R5: When the first overrun is seen, `tripped_o` goes high one cycle later. At the same time `stall_o` takes bit i for every channel i over its limit in that cycle. Both then hold until reset, and later overruns add no bits.
- R6: A disabled channel never blocks service, and its timer is held at zero. When it is re-enabled, its timer counts from zero.
- R7: A clear for a channel in the same cycle as a tick leaves that channel's timer at zero.
- R8: Timers saturate at 2^16-1 and do not wrap. A channel whose limit is 16'hFFFF never runs over.
- R9: A write is taken when `wr_en_i` is high. `wr_op_i` selects the action on channel `wr_ch_i`: 0 clears the timer, 1 loads the limit from `wr_data_i`, 2 loads the enable from `wr_data_i[0]`, and 3 does nothing. A loaded value takes effect from the next cycle.
- R10: Channels are independent: each one expires according to its own limit and clears only, and `stall_o` bit i belongs to channel i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle millisecond tick strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_op_i | input | 2 | Write action: 0 clear, 1 limit, 2 enable, 3 none |
| wr_ch_i | input | 3 | Target channel index |
| wr_data_i | input | 16 | Limit value, or enable in bit 0 |
| kick_o | output | 1 | One-cycle service pulse for the hardware watchdog |
| stall_o | output | 8 | Sticky per-channel overrun status |
| tripped_o | output | 1 | Sticky flag: service has stopped |

## Verification
Two events can fall in the same cycle: a channel clear and the tick that would otherwise advance that channel's timer. The bench provokes this in two ways. It issues a clear to a short-limit channel on every tick cycle for a long run. It also scatters clears across random tick patterns. It judges the collision by whether service ever stops, and by how many ticks the channel survives once the clears cease. A cycle model built from the requirements predicts the pulse, status and flag on every cycle.

// File: rtl/twd_pkg.sv
`timescale 1ns/1ps
package twd_pkg;
    localparam int OP_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_CLEAR  = 2'd0,
        OP_LIMIT  = 2'd1,
        OP_ENABLE = 2'd2,
        OP_NONE   = 2'd3
    } twd_op_e;
endpackage

// File: rtl/twd_chan.sv
`timescale 1ns/1ps
module twd_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic             lim_we_i,
    input  logic             en_we_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic             over_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
        logic             en;
    } chan_s;

    chan_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (lim_we_i) s_d.lim = wr_data_i;
        if (en_we_i)  s_d.en  = wr_data_i[0];
        if (clr_i)
            s_d.cnt = '0;
        else if (!s_q.en)
            s_d.cnt = '0;
        else if (tick_i && (s_q.cnt != CNT_MAX))
            s_d.cnt = s_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q.cnt <= '0;
            s_q.lim <= CNT_MAX;
            s_q.en  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign over_o = s_q.en && (s_q.cnt > s_q.lim);

    // R7
    clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (s_q.cnt == '0));

    // R8
    cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.cnt == CNT_MAX && s_q.en && !clr_i) |=> (s_q.cnt == CNT_MAX));

    // R6
    dis_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !s_q.en |=> (s_q.cnt == '0));

    // R3
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && s_q.en && !clr_i && s_q.cnt != CNT_MAX)
            |=> (s_q.cnt == $past(s_q.cnt) + CNT_W'(1)));
endmodule

// File: rtl/twd_gate.sv
`timescale 1ns/1ps
module twd_gate #(
    parameter int NUM_CH = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [NUM_CH-1:0] over_i,
    output logic              kick_o,
    output logic [NUM_CH-1:0] stall_o,
    output logic              tripped_o
);
    typedef struct packed {
        logic              kick;
        logic              tripped;
        logic [NUM_CH-1:0] stall;
    } gate_s;

    gate_s g_d, g_q;
    logic  any_over;

    assign any_over = |over_i;

    always_comb begin
        g_d      = g_q;
        g_d.kick = tick_i && !g_q.tripped && !any_over;
        if (!g_q.tripped && any_over) begin
            g_d.tripped = 1'b1;
            g_d.stall   = over_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign kick_o    = g_q.kick;
    assign stall_o   = g_q.stall;
    assign tripped_o = g_q.tripped;

    // R2
    kick_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        g_q.kick |-> $past(tick_i));

    // R4
    kick_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        g_q.tripped |=> !g_q.kick);

    // R5
    stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        g_q.tripped |=> (g_q.tripped && $stable(g_q.stall)));

    // R5
    trip_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        g_q.tripped |-> (g_q.stall != '0));
endmodule

// File: rtl/task_wdog_agg.sv
`timescale 1ns/1ps
module task_wdog_agg #(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     tick_i,
    input  logic                     wr_en_i,
    input  logic [twd_pkg::OP_W-1:0] wr_op_i,
    input  logic [CH_W-1:0]          wr_ch_i,
    input  logic [CNT_W-1:0]         wr_data_i,
    output logic                     kick_o,
    output logic [NUM_CH-1:0]        stall_o,
    output logic                     tripped_o
);
    import twd_pkg::*;

    twd_op_e           op;
    logic [NUM_CH-1:0] over;

    assign op = twd_op_e'(wr_op_i);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic hit;
        assign hit = wr_en_i && (wr_ch_i == CH_W'(g));

        twd_chan #(.CNT_W(CNT_W)) u_chan (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .tick_i    (tick_i),
            .clr_i     (hit && (op == OP_CLEAR)),
            .lim_we_i  (hit && (op == OP_LIMIT)),
            .en_we_i   (hit && (op == OP_ENABLE)),
            .wr_data_i (wr_data_i),
            .over_o    (over[g])
        );
    end

    twd_gate #(.NUM_CH(NUM_CH)) u_gate (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .over_i    (over),
        .kick_o    (kick_o),
        .stall_o   (stall_o),
        .tripped_o (tripped_o)
    );

    // R10
    stall_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tripped_o && over != '0) |=> (stall_o == $past(over)));
endmodule

// File: tb/task_wdog_agg_bench.sv
`timescale 1ns/1ps
module task_wdog_agg_bench;
    localparam int NCH = 8;
    localparam int CW  = 16;
    localparam int SW  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic wen = 1'b0;
    logic [1:0] wop = 2'd0;
    logic [SW-1:0] wch = '0;
    logic [CW-1:0] wdat = '0;
    logic kick;
    logic [NCH-1:0] stall;
    logic tripped;

    always #2.5 clk = ~clk;

    task_wdog_agg u_task_wdog_agg (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wen),
        .wr_op_i(wop), .wr_ch_i(wch), .wr_data_i(wdat),
        .kick_o(kick), .stall_o(stall), .tripped_o(tripped)
    );

    logic [CW-1:0] m_cnt [NCH];
    logic [CW-1:0] m_lim [NCH];
    logic          m_en  [NCH];
    logic          m_trip;
    logic          m_kick;
    logic [NCH-1:0] m_stall;

    int n_chk = 0;
    int n_fail = 0;
    string req = "R1";
    int kicks = 0;

    task automatic chk(string r, logic [31:0] act, logic [31:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    task automatic m_reset();
        for (int i = 0; i < NCH; i++) begin
            m_cnt[i] = '0; m_lim[i] = '1; m_en[i] = 1'b0;
        end
        m_trip = 1'b0; m_kick = 1'b0; m_stall = '0;
    endtask

    task automatic step(bit t, bit we, logic [1:0] op, int ch, logic [CW-1:0] d);
        logic [NCH-1:0] e;
        tick = t; wen = we; wop = op; wch = SW'(ch); wdat = d;
        @(posedge clk);
        for (int i = 0; i < NCH; i++) e[i] = m_en[i] && (m_cnt[i] > m_lim[i]);
        m_kick = t && !m_trip && (e == '0);
        if (!m_trip && e != '0) begin m_trip = 1'b1; m_stall = e; end
        for (int i = 0; i < NCH; i++) begin
            if (we && op == 2'd0 && ch == i) m_cnt[i] = '0;
            else if (!m_en[i]) m_cnt[i] = '0;
            else if (t && m_cnt[i] != 16'hFFFF) m_cnt[i] = m_cnt[i] + 16'd1;
            if (we && op == 2'd1 && ch == i) m_lim[i] = d;
            if (we && op == 2'd2 && ch == i) m_en[i] = d[0];
        end
        #1;
        chk(req, 32'(kick), 32'(m_kick), "kick");
        chk(req, 32'(stall), 32'(m_stall), "status");
        chk(req, 32'(tripped), 32'(m_trip), "tripped");
        if (kick) kicks++;
        tick = 1'b0; wen = 1'b0;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step(0, 0, 2'd0, 0, '0);
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) step(1, 0, 2'd0, 0, '0);
    endtask

    task automatic setup(int ch, logic [CW-1:0] lim, bit en);
        step(0, 1, 2'd1, ch, lim);
        step(0, 1, 2'd2, ch, CW'(en));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick = 1'b0; wen = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        m_reset();
        chk("R1", 32'(kick), 0, "reset kick");
        chk("R1", 32'(stall), 0, "reset status");
        chk("R1", 32'(tripped), 0, "reset tripped");
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));

        // R1: defaults, enabled channel with all-ones limit never trips
        req = "R1";
        do_reset();
        step(0, 1, 2'd2, 0, 16'd1);
        ticks(300);
        chk("R1", 32'(tripped), 0, "default limit tripped");

        // R2: random tick pattern with no channels enabled
        req = "R2";
        do_reset();
        begin
            int nt = 0;
            kicks = 0;
            for (int k = 0; k < 200; k++) begin
                bit t = ($urandom % 3) == 0;
                if (t) nt++;
                step(t, 0, 2'd0, 0, '0);
            end
            chk("R2", 32'(kicks), 32'(nt), "kick count vs tick count");
        end

        // R3: limit 5 gives six serviced ticks
        req = "R3";
        do_reset();
        setup(0, 16'd5, 1'b1);
        kicks = 0;
        ticks(10);
        chk("R3", 32'(kicks), 6, "serviced ticks for limit 5");
        chk("R3", 32'(stall), 32'h01, "status after overrun");

        // R4: after trip nothing restores service
        req = "R4";
        for (int i = 0; i < NCH; i++) step(1, 1, 2'd0, i, '0);
        step(0, 1, 2'd2, 0, 16'd0);
        kicks = 0;
        ticks(40);
        chk("R4", 32'(kicks), 0, "kicks after trip");

        // R10: ch0 limit 20 unserviced, ch3 limit 6 cleared often
        req = "R10";
        do_reset();
        setup(0, 16'd20, 1'b1);
        setup(3, 16'd6, 1'b1);
        for (int k = 0; k < 40; k++) begin
            if (k % 5 == 4) step(1, 1, 2'd0, 3, '0);
            else step(1, 0, 2'd0, 0, '0);
        end
        chk("R10", 32'(stall), 32'h01, "only ch0 flagged");

        // R5: two channels expire together, a third later adds nothing
        req = "R5";
        do_reset();
        setup(2, 16'd4, 1'b1);
        setup(6, 16'd4, 1'b1);
        setup(1, 16'd8, 1'b1);
        ticks(15);
        chk("R5", 32'(stall), 32'h44, "simultaneous overrun bits");
        chk("R5", 32'(tripped), 1, "trip flag");

        // R7: clear on every tick keeps a short-limit channel alive
        req = "R7";
        do_reset();
        setup(1, 16'd2, 1'b1);
        for (int k = 0; k < 60; k++) step(1, 1, 2'd0, 1, '0);
        chk("R7", 32'(tripped), 0, "clear with tick");
        kicks = 0;
        ticks(5);
        chk("R7", 32'(kicks), 3, "ticks serviced after last clear");

        // R6: disable holds zero, re-enable counts from zero
        req = "R6";
        do_reset();
        setup(4, 16'd3, 1'b1);
        ticks(3);
        step(0, 1, 2'd2, 4, 16'd0);
        ticks(20);
        chk("R6", 32'(tripped), 0, "disabled channel blocks");
        step(0, 1, 2'd2, 4, 16'd1);
        ticks(4);
        chk("R6", 32'(tripped), 0, "restart from zero early");
        idle(1);
        chk("R6", 32'(tripped), 1, "restart from zero expiry");

        // R9: op 3 ignored, data 0 does not disable or clear
        req = "R9";
        do_reset();
        setup(0, 16'd3, 1'b1);
        ticks(2);
        step(1, 1, 2'd3, 0, 16'd0);
        ticks(2);
        idle(1);
        chk("R9", 32'(tripped), 1, "no-op write ignored");

        // R9/R4/R5: random mix
        for (int r = 0; r < 20; r++) begin
            req = "R9";
            do_reset();
            for (int i = 0; i < NCH; i++) setup(i, CW'(4 + $urandom % 30), 1'(($urandom % 2)));
            for (int k = 0; k < 300; k++) begin
                bit t = ($urandom % 3) == 0;
                bit we = ($urandom % 2) == 1;
                logic [1:0] op = 2'($urandom % 4);
                int ch = int'($urandom % NCH);
                logic [CW-1:0] d = (op == 2'd1) ? CW'(4 + $urandom % 30) : CW'($urandom);
                step(t, we, op, ch, d);
            end
        end

        // R8: saturation at all ones
        req = "R8";
        do_reset();
        setup(5, 16'hFFFF, 1'b1);
        ticks(65540);
        chk("R8", 32'(tripped), 0, "max limit never overruns");
        step(0, 1, 2'd1, 5, 16'hFFFE);
        idle(3);
        chk("R8", 32'(tripped), 1, "saturated count over FFFE");
        chk("R8", 32'(stall), 32'h20, "saturated channel flagged");

        summary();
        $finish;
    end
endmodule